// File: doc/BRIEF.md
# General-Purpose I/O Bank with Interrupt Detection

This block serves 32 general-purpose pins behind a small memory-mapped register port. Software drives an output latch and a per-pin output enable. It can read either the pin levels, which come through a synchronizer, or the latch contents, which come back unchanged. The value view always shows the synchronized pin, including for pins that are driven as outputs, so a read that follows a write at once can still return the old level.

Each pin also has an event detector. Three per-pin type bits choose the mode: rising edge, falling edge, both edges, high level or low level. Detected events set sticky status bits. Software clears a status bit by writing 1 to it. An enable mask decides which status bits reach the single combined interrupt line.

The register port is a single-cycle write strobe with a byte address. Read data is combinational from the address, and a read has no side effects.

Top module: `gpio_bank`

## Requirements
- R1: A read at offset 0x00 returns the pin levels after a two-flop synchronizer. A pin change driven before clock edge k is first visible after edge k+1. This holds for pins configured as outputs too.
- R2: A write at offset 0x00 loads the output latch, which drives `pin_out`. A write at offset 0x04 loads the direction mask, where bit value 1 means output and drives `pin_oe`.
- R3: A read at offset 0x08 returns the output latch. A write to offset 0x08 changes no register and no output.
- R4: After reset, the latch, direction, enable (0x10), type (0x14, 0x18, 0x1C) and status (0x20) registers read as 0. `pin_oe` is 0 and `irq` is 0.
- R5: A pin with type bits t0=0 (offset 0x14), t1=1 (0x18) and t2=0 (0x1C) sets its status bit on a rising edge only.
- R6: A pin with t0=0, t1=0 and t2=0 sets its status bit on a falling edge only. This is the reset mode.
- R7: A pin with t0=0 and t2=1 sets its status bit on both edges, whatever the value of t1.
- R8: A pin with t0=1 is level sensitive. With t1=1 it sets while the pin is high, and with t1=0 it sets while the pin is low. In this mode t2 is ignored.
- R9: Writing 1 to a bit at offset 0x20 clears that status bit, and 0 bits leave their status bits unchanged. An edge event in the same cycle as the clear keeps the bit set.
- R10: When a level-mode status bit is cleared while its condition still holds, it reads 0 for one cycle and then sets again.
- R11: `irq` is the OR of the status bits ANDed with the enable bits at offset 0x10. Status bits latch events even when their enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench samples the value register one and two cycles after a pin change. A design with the wrong synchronizer depth would show the new level too early or too late. It fires an edge in exactly the cycle that a clear is written. A design where the clear wins would lose that event. It clears a level interrupt whose condition still holds and checks for the one-cycle gap followed by the re-set. A design that let the level win would never show 0, and one that forgot to re-evaluate would stay cleared. It also sets both t1 and t2 for a pin and checks that a falling edge still triggers, and sets t2 on a level pin and checks that the bit is ignored. Finally, it writes the read-back offset and checks that the latch is unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int OFF_VALUE   = 'h00;
    localparam int OFF_DIR     = 'h04;
    localparam int OFF_LATCHRB = 'h08;
    localparam int OFF_IRQ     = 'h10;
    localparam int OFF_EN      = OFF_IRQ + 'h00;
    localparam int OFF_TLEVEL  = OFF_IRQ + 'h04;
    localparam int OFF_THIGH   = OFF_IRQ + 'h08;
    localparam int OFF_TBOTH   = OFF_IRQ + 'h0C;
    localparam int OFF_STATUS  = OFF_IRQ + 'h10;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VALUE,
        SEL_DIR,
        SEL_LATCHRB,
        SEL_EN,
        SEL_TLEVEL,
        SEL_THIGH,
        SEL_TBOTH,
        SEL_STATUS
    } reg_sel_e;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    always_comb begin
        case (addr_i)
            ADDR_W'(OFF_VALUE):   sel_o = SEL_VALUE;
            ADDR_W'(OFF_DIR):     sel_o = SEL_DIR;
            ADDR_W'(OFF_LATCHRB): sel_o = SEL_LATCHRB;
            ADDR_W'(OFF_EN):      sel_o = SEL_EN;
            ADDR_W'(OFF_TLEVEL):  sel_o = SEL_TLEVEL;
            ADDR_W'(OFF_THIGH):   sel_o = SEL_THIGH;
            ADDR_W'(OFF_TBOTH):   sel_o = SEL_TBOTH;
            ADDR_W'(OFF_STATUS):  sel_o = SEL_STATUS;
            default:              sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] sel_level_i,
    input  logic [N-1:0] sel_high_i,
    input  logic [N-1:0] sel_both_i,
    output logic [N-1:0] edge_evt_o,
    output logic [N-1:0] level_evt_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise, fall;
        always_comb begin
            rise = level_i[i] & ~prev_q[i];
            fall = ~level_i[i] & prev_q[i];
            if (sel_level_i[i]) begin
                edge_evt_o[i]  = 1'b0;
                level_evt_o[i] = sel_high_i[i] ? level_i[i] : ~level_i[i];
            end else begin
                level_evt_o[i] = 1'b0;
                if (sel_both_i[i]) edge_evt_o[i] = rise | fall;
                else               edge_evt_o[i] = sel_high_i[i] ? rise : fall;
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] latch;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] t_level;
        logic [NPINS-1:0] t_high;
        logic [NPINS-1:0] t_both;
        logic [NPINS-1:0] status;
    } bank_state_t;

    bank_state_t      st_d, st_q;
    reg_sel_e         sel;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] edge_evt, level_evt;
    logic [NPINS-1:0] ack_mask;

    gpio_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    gpio_pin_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_event_detect #(.N(NPINS)) i_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_i     (pin_sync),
        .sel_level_i (st_q.t_level),
        .sel_high_i  (st_q.t_high),
        .sel_both_i  (st_q.t_both),
        .edge_evt_o  (edge_evt),
        .level_evt_o (level_evt)
    );

    always_comb ack_mask = (bus_wr && sel == SEL_STATUS) ? bus_wdata : '0;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (sel)
                SEL_VALUE:  st_d.latch   = bus_wdata;
                SEL_DIR:    st_d.dir     = bus_wdata;
                SEL_EN:     st_d.en      = bus_wdata;
                SEL_TLEVEL: st_d.t_level = bus_wdata;
                SEL_THIGH:  st_d.t_high  = bus_wdata;
                SEL_TBOTH:  st_d.t_both  = bus_wdata;
                default:    ;
            endcase
        end
        // edges win over a same-cycle clear; levels are re-sampled a cycle later
        st_d.status = (st_q.status & ~ack_mask) | edge_evt | (level_evt & ~ack_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_VALUE:   bus_rdata = pin_sync;
            SEL_DIR:     bus_rdata = st_q.dir;
            SEL_LATCHRB: bus_rdata = st_q.latch;
            SEL_EN:      bus_rdata = st_q.en;
            SEL_TLEVEL:  bus_rdata = st_q.t_level;
            SEL_THIGH:   bus_rdata = st_q.t_high;
            SEL_TBOTH:   bus_rdata = st_q.t_both;
            SEL_STATUS:  bus_rdata = st_q.status;
            default:     bus_rdata = '0;
        endcase
    end

    assign pin_out = st_q.latch;
    assign pin_oe  = st_q.dir;
    assign irq     = |(st_q.status & st_q.en);

    // R3
    rb_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_LATCHRB)) |=> $stable(pin_out));

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFF_DIR)) |=> $stable(pin_oe));

    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq);

    for (genvar i = 0; i < NPINS; i++) begin : g_ack_chk
        // R9
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_mask[i] && !edge_evt[i]) |=> !st_q.status[i]);
    end
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_RB = 6'h08, A_EN = 6'h10,
                           A_T0 = 6'h14, A_T1 = 6'h18, A_T2 = 6'h1C, A_ST = 6'h20;

    always #5 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        logic [31:0] act;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always @(posedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (it.act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, it.act, it.exp);
            end
        end
    end

    task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.act = act; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        push(bus_rdata, exp, tag);
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pin_in[idx] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R4 reset state
        rd(A_VAL, 32'h0, "R4 value");
        rd(A_DIR, 32'h0, "R4 dir");
        rd(A_RB,  32'h0, "R4 latch");
        rd(A_EN,  32'h0, "R4 enable");
        rd(A_T0,  32'h0, "R4 type0");
        rd(A_T1,  32'h0, "R4 type1");
        rd(A_T2,  32'h0, "R4 type2");
        rd(A_ST,  32'h0, "R4 status");
        push(pin_oe, 32'h0, "R4 pin_oe");
        push({31'b0, irq}, 32'h0, "R4 irq");

        // R2 latch and direction
        wr(A_VAL, 32'hA5A5_0F0F);
        push(pin_out, 32'hA5A5_0F0F, "R2 pin_out");
        wr(A_DIR, 32'hFFFF_0000);
        push(pin_oe, 32'hFFFF_0000, "R2 pin_oe");

        // R3 read-back, writes ignored
        rd(A_RB, 32'hA5A5_0F0F, "R3 readback");
        wr(A_RB, 32'h1234_5678);
        rd(A_RB, 32'hA5A5_0F0F, "R3 readback after write");
        push(pin_out, 32'hA5A5_0F0F, "R3 pin_out after write");

        // R1 synchronizer latency, output pin 20 included
        @(negedge clk);
        pin_in = 32'h0010_00F0;
        rd(A_VAL, 32'h0, "R1 same cycle");
        @(negedge clk);
        rd(A_VAL, 32'h0, "R1 one edge");
        @(negedge clk);
        rd(A_VAL, 32'h0010_00F0, "R1 two edges");

        // R6 and R11: falling events latch with enable clear
        @(negedge clk);
        pin_in = 32'h0;
        idle(4);
        rd(A_ST, 32'h0010_00F0, "R6 R11 falls latched");
        push({31'b0, irq}, 32'h0, "R11 irq masked");
        wr(A_EN, 32'h10);
        push({31'b0, irq}, 32'h1, "R11 irq enabled");
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, 32'h0, "R9 clear all");
        push({31'b0, irq}, 32'h0, "R11 irq after clear");

        // R5 rising on pin 8
        wr(A_T1, 32'h100);
        set_pin(8, 1'b1); idle(4);
        rd(A_ST, 32'h100, "R5 rise");
        wr(A_ST, 32'hFFFF_FFFF);
        set_pin(8, 1'b0); idle(4);
        rd(A_ST, 32'h0, "R5 fall ignored");

        // R6 falling on pin 9
        set_pin(9, 1'b1); idle(4);
        rd(A_ST, 32'h0, "R6 rise ignored");
        set_pin(9, 1'b0); idle(4);
        rd(A_ST, 32'h200, "R6 fall");

        // R9 edge coincident with clear
        set_pin(9, 1'b1); idle(4);
        rd(A_ST, 32'h200, "R9 still set");
        set_pin(9, 1'b0);
        @(negedge clk);
        wr(A_ST, 32'h200);
        rd(A_ST, 32'h200, "R9 edge beats clear");
        wr(A_ST, 32'h200);
        rd(A_ST, 32'h0, "R9 plain clear");

        // R7 both edges on pin 10, t1 also set
        wr(A_T1, 32'h500);
        wr(A_T2, 32'h400);
        set_pin(10, 1'b1); idle(4);
        rd(A_ST, 32'h400, "R7 rise");
        wr(A_ST, 32'h400);
        rd(A_ST, 32'h0, "R7 cleared");
        set_pin(10, 1'b0); idle(4);
        rd(A_ST, 32'h400, "R7 fall despite t1");
        wr(A_ST, 32'h400);

        // R8 level high on pin 11, level low on pin 12 with t2 set
        wr(A_T1, 32'hD00);
        wr(A_T2, 32'h1400);
        wr(A_T0, 32'h1800);
        idle(2);
        rd(A_ST, 32'h1000, "R8 level low");
        set_pin(11, 1'b1); idle(4);
        rd(A_ST, 32'h1800, "R8 level high");

        // R10 level re-set after clear, R9 zero bits untouched
        wr(A_ST, 32'h800);
        rd(A_ST, 32'h1000, "R10 gap cycle");
        @(negedge clk);
        rd(A_ST, 32'h1800, "R10 re-set");
        set_pin(11, 1'b0);
        set_pin(12, 1'b1);
        idle(4);
        wr(A_ST, 32'h1800);
        idle(1);
        rd(A_ST, 32'h0, "R8 level gone");

        // R11 enable after latch
        set_pin(9, 1'b1); idle(4);
        set_pin(9, 1'b0); idle(4);
        rd(A_ST, 32'h200, "R11 latched");
        push({31'b0, irq}, 32'h0, "R11 other bit enabled only");
        wr(A_EN, 32'h210);
        push({31'b0, irq}, 32'h1, "R11 enabled late");
        wr(A_ST, 32'h200);
        push({31'b0, irq}, 32'h0, "R11 cleared");

        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule